// File: doc/BRIEF.md
# Pseudo-Carry Lookahead Adder

This block adds two unsigned operands and a carry-in and returns the sum and the carry-out. It is purely combinational, so no clock, reset or handshake is involved. The output follows the inputs within the same evaluation.

The lookahead network does not pass the true carry between bit positions. It passes a pseudo-carry. The pseudo-carry at a bit is high when a carry leaves that bit or enters it, so it covers both cases in one signal.

The adder first forms three per-bit terms from the operands:
- an AND term that generates a carry;
- an OR term that transmits one;
- an XOR term for the half sum.

The pseudo-carry recurrence is written out in closed form inside each four-bit slice. The slices are then linked through slice-level generate and transmit terms. Each sum bit is rebuilt from the pseudo-carry one position below, masked by the OR term at that position.

An operand width that is not a multiple of four is zero-padded internally up to the next whole slice.

Top module: `ling_adder`

## Requirements
- R1: For every operand pair and carry-in, `{carry_out, sum_out}` equals `opa + opb + carry_in` as an unsigned (WIDTH+1)-bit value.
- R2: Sum bit 0 equals `opa[0] ^ opb[0] ^ carry_in`; the carry-in enters as the pseudo-carry below bit 0, with a transmit term of one.
- R3: `carry_out` is 1 exactly when `opa + opb + carry_in` is 2^WIDTH or more.
- R4: A bit position where both operands are 1 always produces a carry into the next position, whatever lies below it. With both operands equal to `1 << k` and no carry-in, the sum is `1 << (k+1)`; for the top bit it is zero with `carry_out` set.
- R5: When `opb` is the bitwise complement of `opa`, a carry-in of 1 travels through every transmit term: the sum is 0 and `carry_out` is 1. With a carry-in of 0, the sum is all ones and `carry_out` is 0.
- R6: A WIDTH that is not a multiple of four gives the same exact result as R1 over all input combinations.
- R7: Every sum bit equals `opa[i] ^ opb[i] ^ c_i`, where `c_i` is the true carry into bit i from a bit-serial carry chain that starts at `carry_in`.
- R8: At the default WIDTH of 16, the corner operands (zero, all ones, the sign bit alone, all ones below the sign bit) give exact results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The embedded assertions assume that both operands and the carry-in hold known 0/1 values. Each check is skipped while any of these inputs is unknown, which covers the moments before the bench first drives them. The stimulus sets every input of every instance at time zero and only ever changes them to fully specified values, so the guards matter only at start-up. The pseudo-carry invariants are checked in the same evaluation as the arithmetic result:
- a generating bit sets its own pseudo-carry;
- a true carry out of a bit sets the pseudo-carry of the bit above;
- the slice-chain result agrees with the top bit of each unrolled slice.

// File: rtl/ling_pkg.sv
package ling_pkg;
  // Bits per unrolled pseudo-carry slice; ling_group is written for four.
  localparam int unsigned GRP_W = 4;

  function automatic int unsigned grp_count(input int unsigned width);
    return (width + GRP_W - 1) / GRP_W;
  endfunction
endpackage

// File: rtl/ling_local_terms.sv
module ling_local_terms #(
  parameter int unsigned PADW = 16
) (
  input  logic [PADW-1:0] pa,
  input  logic [PADW-1:0] pb,
  output logic [PADW-1:0] gen,
  output logic [PADW-1:0] xmit,
  output logic [PADW-1:0] half
);
  for (genvar i = 0; i < PADW; i++) begin : g_bit
    assign gen[i]  = pa[i] & pb[i];
    assign xmit[i] = pa[i] | pb[i];
    assign half[i] = pa[i] ^ pb[i];
  end
endmodule

// File: rtl/ling_group.sv
module ling_group (
  input  logic [3:0] gen,
  input  logic [2:0] xmit,   // transmit terms of slice bits 0..2
  input  logic       t_lo,   // transmit term of the bit below the slice
  input  logic       h_lo,   // pseudo-carry of the bit below the slice
  output logic [3:0] hp,     // pseudo-carries of the four slice bits
  output logic       hg,     // slice pseudo-generate
  output logic       ht      // slice pseudo-transmit
);
  logic entry;

  assign entry = t_lo & h_lo;

  assign hp[0] = gen[0] | entry;
  assign hp[1] = gen[1] | (xmit[0] & gen[0]) | (xmit[0] & entry);
  assign hp[2] = gen[2] | (xmit[1] & gen[1]) | (xmit[1] & xmit[0] & gen[0])
               | (xmit[1] & xmit[0] & entry);
  assign hp[3] = gen[3] | (xmit[2] & gen[2]) | (xmit[2] & xmit[1] & gen[1])
               | (xmit[2] & xmit[1] & xmit[0] & gen[0])
               | (xmit[2] & xmit[1] & xmit[0] & entry);

  assign hg = gen[3] | (xmit[2] & gen[2]) | (xmit[2] & xmit[1] & gen[1])
            | (xmit[2] & xmit[1] & xmit[0] & gen[0]);
  assign ht = xmit[2] & xmit[1] & xmit[0] & t_lo;
endmodule

// File: rtl/ling_group_chain.sv
module ling_group_chain #(
  parameter int unsigned NGRP = 4
) (
  input  logic [NGRP-1:0] hg,
  input  logic [NGRP-1:0] ht,
  input  logic            cin,
  output logic [NGRP-1:0] hbnd   // pseudo-carry of the top bit of each slice
);
  always_comb begin
    logic run;
    run = cin;
    for (int k = 0; k < NGRP; k++) begin
      run     = hg[k] | (ht[k] & run);
      hbnd[k] = run;
    end
  end
endmodule

// File: rtl/ling_sum.sv
module ling_sum #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned PADW  = 16
) (
  input  logic [PADW-1:0] half,
  input  logic [PADW-1:0] xmit,
  input  logic [PADW-1:0] hp,
  input  logic            cin,
  output logic [PADW-1:0] psum,
  output logic            cout
);
  logic [PADW-1:0] gtrue;   // true carry out of each bit
  logic            unused_top;

  for (genvar i = 0; i < PADW; i++) begin : g_bit
    assign gtrue[i] = xmit[i] & hp[i];
    if (i == 0) begin : g_lsb
      assign psum[i] = half[i] ^ cin;
    end else begin : g_upper
      assign psum[i] = half[i] ^ gtrue[i-1];
    end
  end

  assign cout       = gtrue[WIDTH-1];
  assign unused_top = gtrue[PADW-1];

  // A carry entering a bit must show up in that bit's pseudo-carry.
  always_comb begin
    if (!$isunknown({half, xmit, hp, cin})) begin
      p_h_covers_carry_in_r7: assert (!cin || hp[0]);
      for (int i = 1; i < PADW; i++) begin
        p_h_covers_carry_r7: assert (!gtrue[i-1] || hp[i]);
      end
    end
  end
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int unsigned NGRP = grp_count(WIDTH);
  localparam int unsigned PADW = NGRP * GRP_W;

  logic [PADW-1:0] pa, pb;
  logic [PADW-1:0] gvec, tvec, xvec, hvec, psum;
  logic [NGRP-1:0] grp_hg, grp_ht, hbnd;
  logic            unused_pad;

  assign pa = PADW'(opa);
  assign pb = PADW'(opb);

  ling_local_terms #(.PADW(PADW)) u_terms (
    .pa(pa), .pb(pb), .gen(gvec), .xmit(tvec), .half(xvec)
  );

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int unsigned B = k * GRP_W;
    logic t_lo, h_lo;
    if (k == 0) begin : g_first
      assign t_lo = 1'b1;
      assign h_lo = carry_in;
    end else begin : g_rest
      assign t_lo = tvec[B-1];
      assign h_lo = hbnd[k-1];
    end
    ling_group u_grp (
      .gen  (gvec[B +: GRP_W]),
      .xmit (tvec[B +: GRP_W-1]),
      .t_lo (t_lo),
      .h_lo (h_lo),
      .hp   (hvec[B +: GRP_W]),
      .hg   (grp_hg[k]),
      .ht   (grp_ht[k])
    );
  end

  ling_group_chain #(.NGRP(NGRP)) u_chain (
    .hg(grp_hg), .ht(grp_ht), .cin(carry_in), .hbnd(hbnd)
  );

  ling_sum #(.WIDTH(WIDTH), .PADW(PADW)) u_sum (
    .half(xvec), .xmit(tvec), .hp(hvec), .cin(carry_in),
    .psum(psum), .cout(carry_out)
  );

  assign sum_out    = psum[WIDTH-1:0];
  assign unused_pad = ^psum;

  // Arithmetic reference used only by the assertions below.
  logic [WIDTH:0] ref_total;
  assign ref_total = (WIDTH+1)'(opa) + (WIDTH+1)'(opb) + (WIDTH+1)'(carry_in);

  always_comb begin
    if (!$isunknown({opa, opb, carry_in})) begin
      p_sum_exact_r1: assert ({carry_out, sum_out} == ref_total);
      p_cout_exact_r3: assert (carry_out == ref_total[WIDTH]);
      for (int i = 0; i < PADW; i++) begin
        p_gen_marks_h_r4: assert (!gvec[i] || hvec[i]);
      end
      for (int k = 0; k < NGRP; k++) begin
        p_boundary_agree_r1: assert (hvec[k*GRP_W + GRP_W - 1] == hbnd[k]);
      end
    end
  end
endmodule

// File: tb/ling_adder_test.sv
module ling_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // 8-bit instance: exhaustive sweep
  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  ling_adder #(.WIDTH(8)) uut (
    .opa(a8), .opb(b8), .carry_in(c8), .sum_out(s8), .carry_out(co8));

  // 6-bit instance: padded slice
  logic [5:0]  a6 = '0, b6 = '0, s6;
  logic        c6 = 1'b0, co6;
  ling_adder #(.WIDTH(6)) uut_odd (
    .opa(a6), .opb(b6), .carry_in(c6), .sum_out(s6), .carry_out(co6));

  // default-width instance: directed corners
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  ling_adder uut_wide (
    .opa(a16), .opb(b16), .carry_in(c16), .sum_out(s16), .carry_out(co16));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial reference carry chain: {carry_out, sum}
  function automatic logic [31:0] ripple(input logic [15:0] a, input logic [15:0] b,
                                         input logic ci, input int w);
    logic [31:0] r;
    logic c;
    r = '0;
    c = ci;
    for (int i = 0; i < w; i++) begin
      r[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
    end
    r[w] = c;
    return r;
  endfunction

  task automatic wide_case(input string req, input logic [15:0] a, input logic [15:0] b,
                           input logic ci);
    logic [16:0] tot;
    @(posedge clk);
    a16 = a; b16 = b; c16 = ci;
    @(negedge clk);
    tot = 17'(a) + 17'(b) + 17'(ci);
    check(req, {15'd0, co16, s16}, {15'd0, tot});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] tot9;
    logic [6:0] tot7;
    logic [15:0] lf;

    // all-zero inputs (R1)
    @(negedge clk);
    check("R1 zero inputs", {23'd0, co8, s8}, 32'd0);

    // R1/R2/R3/R7: exhaustive 8-bit
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          @(posedge clk);
          a8 = 8'(a); b8 = 8'(b); c8 = 1'(ci);
          @(negedge clk);
          tot9 = 9'(a) + 9'(b) + 9'(ci);
          check("R1 exact total", {23'd0, co8, s8}, {23'd0, tot9});
          check("R2 sum bit0", {31'd0, s8[0]}, {31'd0, 1'(a) ^ 1'(b) ^ 1'(ci)});
          check("R3 carry out", {31'd0, co8}, {31'd0, (a + b + ci) >= 256});
          check("R7 ripple carries", {23'd0, co8, s8},
                ripple(16'(a), 16'(b), 1'(ci), 8));
        end
      end
    end

    // R6: exhaustive 6-bit (padded slice)
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          @(posedge clk);
          a6 = 6'(a); b6 = 6'(b); c6 = 1'(ci);
          @(negedge clk);
          tot7 = 7'(a) + 7'(b) + 7'(ci);
          check("R6 padded width", {25'd0, co6, s6}, {25'd0, tot7});
        end
      end
    end

    // R4: generate at bit k with nothing else
    for (int k = 0; k < 16; k++) begin
      @(posedge clk);
      a16 = 16'(1) << k; b16 = 16'(1) << k; c16 = 1'b0;
      @(negedge clk);
      check("R4 generate", {15'd0, co16, s16}, 32'(1) << (k + 1));
      // generate with noise below it still carries into bit k+1
      wide_case("R4 generate with low bits", (16'(1) << k) | 16'h0055 >> (16 - k),
                16'(1) << k, 1'b1);
    end

    // R5: full transmit chain
    foreach (lf[i]) lf[i] = i[0];
    for (int p = 0; p < 6; p++) begin
      logic [15:0] pat;
      pat = (p == 0) ? 16'h0000 : (p == 1) ? 16'hffff : (p == 2) ? 16'haaaa :
            (p == 3) ? 16'h0f0f : (p == 4) ? 16'h8001 : 16'h1234;
      @(posedge clk);
      a16 = pat; b16 = ~pat; c16 = 1'b1;
      @(negedge clk);
      check("R5 transmit with carry-in", {15'd0, co16, s16}, 32'h0001_0000);
      @(posedge clk);
      c16 = 1'b0;
      @(negedge clk);
      check("R5 transmit without carry-in", {15'd0, co16, s16}, 32'h0000_ffff);
    end

    // R8: default-width corners
    wide_case("R8 zero", 16'h0000, 16'h0000, 1'b0);
    wide_case("R8 all ones plus carry", 16'hffff, 16'hffff, 1'b1);
    wide_case("R8 all ones plus one", 16'hffff, 16'h0000, 1'b1);
    wide_case("R8 sign bits", 16'h8000, 16'h8000, 1'b0);
    wide_case("R8 below sign", 16'h7fff, 16'h0001, 1'b0);
    wide_case("R8 slice edge", 16'h0fff, 16'h0001, 1'b0);
    wide_case("R8 slice edge carry", 16'h00ff, 16'h0f00, 1'b1);

    // R8: LFSR-driven operands at default width
    lf = 16'hace1;
    for (int n = 0; n < 200; n++) begin
      logic [15:0] ra, rb;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ra = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rb = lf ^ 16'h5a5a;
      wide_case("R8 pseudo-random", ra, rb, lf[0]);
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule